// File: doc/BRIEF.md
# Variable-Precision Lane Dispatcher

This block sits in front of four narrow floating-point arithmetic lanes and decides how a request of up to four operations is spread over them. A start pulse captures a 2-bit mode code, a 2-bit precision code, a 2-bit opcode and twelve 64-bit operand words: four A words, four B words and four C words. The mode and precision pair selects one of six configurations. These are one exact double operation, two or four approximate double operations, two exact or four approximate single operations, and four exact half operations. Any other pair is refused with a one-cycle error pulse.

Narrow values travel inside 64-bit words whose unused upper bits are all ones. Exact configurations hand each lane the raw low bits of its operand words and re-pad the lane result. Approximate configurations demote each operand to the narrower lane format, rounding to nearest with ties to even, and widen each lane result back to the caller's precision without loss. Every lane is reached through a request/acknowledge port. The block raises done when the last active lane has answered, and the four output words are written at that same edge.

Top module: `vp_lane_dispatch`

## Requirements
- R1: Mode 2'b11 with precision 2'b11 runs one exact double operation on lane 0 with lane format code 2'b11. The 64-bit lane result appears unchanged on output 0, and lanes 1 to 3 are never requested.
- R2: Mode 2'b10 with precision 2'b11 runs two operations on lanes 0 and 1 with lane format 2'b10 (single). Each double operand is rounded to single with round-to-nearest-even, and overflow becomes infinity. Each single result is widened exactly to a double output.
- R3: Mode 2'b01 with precision 2'b11 runs four operations with lane format 2'b01 (half). Rounding and widening follow R2: magnitudes above the half range become infinity, and half subnormals are produced and widened exactly.
- R4: Mode 2'b10 with precision 2'b10 runs two exact single operations. Each lane receives bits [31:0] of its operand words, and its output is {32'hFFFFFFFF, result[31:0]}.
- R5: Mode 2'b01 with precision 2'b10 runs four approximate operations on half lanes. The single operand in bits [31:0] is rounded to half as in R3, and the half result is widened exactly to single and padded as in R4.
- R6: Mode 2'b01 with precision 2'b01 runs four exact half operations. Each lane receives bits [15:0], and its output is {48 ones, result[15:0]}.
- R7: Any other mode/precision pair raises err for exactly the cycle after the start edge. It issues no lane request, no done, and leaves the outputs unchanged.
- R8: At done, every output word beyond the active operation count is zero.
- R9: Each lane request stays high until that lane acknowledges. Done is a single-cycle pulse, taken at the edge where the final acknowledge is accepted, with all requests low.
- R10: A start pulse while operations are outstanding is ignored. A start in the cycle where done is high is accepted.
- R11: Every lane sees the captured opcode, held steady for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture codes and operands when idle |
| mode | input | 2 | Operation count / exactness code |
| prec | input | 2 | Precision of caller words (11 double, 10 single, 01 half) |
| opcode | input | 2 | Arithmetic selector passed to every lane |
| op_a | input | 4x64 | A operand words, index = operation |
| op_b | input | 4x64 | B operand words |
| op_c | input | 4x64 | C operand words |
| result | output | 4x64 | Output words, written at done |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-pair pulse |
| lane_req | output | 4 | Per-lane request, held until acknowledge |
| lane_fmt | output | 2 | Lane format code for the current operation |
| lane_op | output | 2 | Opcode for the lanes |
| lane_a | output | 4x64 | Lane A operand, raw bits right-aligned |
| lane_b | output | 4x64 | Lane B operand |
| lane_c | output | 4x64 | Lane C operand |
| lane_ack | input | 4 | Per-lane result valid |
| lane_res | input | 4x64 | Per-lane result, raw bits right-aligned |

## Verification
The completion of one request and the acceptance of the next can share a cycle. Done pulses at the edge that accepts the final acknowledge, and the block is idle in that same cycle, so a start presented while done is high must be taken. The bench provokes this by driving start with a new configuration at the very sample where it sees done. Both results must then arrive in order with their own formats. A start that falls inside the busy window must leave no trace: it carries an unsupported pair, so any acceptance would show up as an error pulse or a corrupted result.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

    localparam int LANES = 4;
    localparam int WORD  = 64;
    localparam int CNT_W = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        FMT_NONE = 2'b00,
        FMT_HALF = 2'b01,
        FMT_SGL  = 2'b10,
        FMT_DBL  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic             ok;
        logic [CNT_W-1:0] count;
        fmt_e             io_fmt;
        fmt_e             lane_fmt;
    } cfg_t;

    function automatic int exp_bits(input fmt_e f);
        case (f)
            FMT_DBL: return 11;
            FMT_SGL: return 8;
            default: return 5;
        endcase
    endfunction

    function automatic int man_bits(input fmt_e f);
        case (f)
            FMT_DBL: return 52;
            FMT_SGL: return 23;
            default: return 10;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [CNT_W-1:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    // keep only the bits a format occupies
    function automatic logic [WORD-1:0] unpad(input logic [WORD-1:0] x, input fmt_e f);
        case (f)
            FMT_SGL:  return {32'd0, x[31:0]};
            FMT_HALF: return {48'd0, x[15:0]};
            default:  return x;
        endcase
    endfunction

    // fill unused upper bits with ones
    function automatic logic [WORD-1:0] pad(input logic [WORD-1:0] x, input fmt_e f);
        case (f)
            FMT_SGL:  return {32'hFFFF_FFFF, x[31:0]};
            FMT_HALF: return {48'hFFFF_FFFF_FFFF, x[15:0]};
            default:  return x;
        endcase
    endfunction

    // double -> narrower format, round to nearest even, overflow to infinity
    function automatic logic [WORD-1:0] narrow_fp(input logic [63:0] d, input int ew, input int mw);
        logic [63:0] sig, kept, mag, emax;
        logic        g, s;
        int          de, ue, sh, t;
        emax = (64'd1 << ew) - 64'd1;
        de   = int'(d[62:52]);
        sig  = {11'd0, 1'b1, d[51:0]};
        ue   = de - 1023 + ((1 << (ew - 1)) - 1);
        if (de == 2047) begin
            mag = (emax << mw) |
                  ((d[51:0] != 52'd0) ? ((64'd1 << (mw - 1)) | ({12'd0, d[51:0]} >> (52 - mw))) : 64'd0);
        end else if (de == 0) begin
            mag = 64'd0;
        end else if (ue >= int'(emax)) begin
            mag = emax << mw;
        end else begin
            sh = (ue < 1) ? (1 - ue) : 0;
            if (sh > 11 + mw) sh = 11 + mw;
            t    = 52 - mw + sh;
            kept = sig >> t;
            g    = sig[t-1];
            s    = |(sig & ((64'd1 << (t - 1)) - 64'd1));
            if (g && (s || kept[0])) kept = kept + 64'd1;
            mag = (sh > 0) ? kept : ((64'(ue - 1) << mw) + kept);
        end
        return ({63'd0, d[63]} << (ew + mw)) | mag;
    endfunction

    // narrower format -> double, exact
    function automatic logic [63:0] widen_fp(input logic [WORD-1:0] x, input int ew, input int mw);
        logic [63:0] e, m, emax, frac;
        logic        sgn;
        int          bias, p, de;
        emax = (64'd1 << ew) - 64'd1;
        sgn  = x[ew+mw];
        e    = (x >> mw) & emax;
        m    = x & ((64'd1 << mw) - 64'd1);
        bias = (1 << (ew - 1)) - 1;
        if (e == emax) begin
            frac = m << (52 - mw);
            return {sgn, 11'h7FF, frac[51:0]};
        end
        if (e == 64'd0 && m == 64'd0) return {sgn, 63'd0};
        if (e == 64'd0) begin
            p = 0;
            for (int i = 0; i < 52; i++) if (i < mw && m[i]) p = i;
            de   = p - mw + 1 - bias + 1023;
            frac = m << (52 - p);
        end else begin
            de   = int'(e) - bias + 1023;
            frac = m << (52 - mw);
        end
        return {sgn, 11'(de), frac[51:0]};
    endfunction

endpackage

// File: rtl/vpd_decode.sv
module vpd_decode
    import vpd_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] prec,
    output cfg_t       cfg
);
    always_comb begin
        cfg = '{ok: 1'b0, count: '0, io_fmt: FMT_NONE, lane_fmt: FMT_NONE};
        case ({mode, prec})
            4'b11_11: cfg = '{ok: 1'b1, count: CNT_W'(1), io_fmt: FMT_DBL,  lane_fmt: FMT_DBL};
            4'b10_11: cfg = '{ok: 1'b1, count: CNT_W'(2), io_fmt: FMT_DBL,  lane_fmt: FMT_SGL};
            4'b01_11: cfg = '{ok: 1'b1, count: CNT_W'(4), io_fmt: FMT_DBL,  lane_fmt: FMT_HALF};
            4'b10_10: cfg = '{ok: 1'b1, count: CNT_W'(2), io_fmt: FMT_SGL,  lane_fmt: FMT_SGL};
            4'b01_10: cfg = '{ok: 1'b1, count: CNT_W'(4), io_fmt: FMT_SGL,  lane_fmt: FMT_HALF};
            4'b01_01: cfg = '{ok: 1'b1, count: CNT_W'(4), io_fmt: FMT_HALF, lane_fmt: FMT_HALF};
            default:  ;
        endcase
    end
endmodule

// File: rtl/vpd_lane_fmt.sv
module vpd_lane_fmt
    import vpd_pkg::*;
(
    input  cfg_t            cfg,
    input  logic [WORD-1:0] wa,
    input  logic [WORD-1:0] wb,
    input  logic [WORD-1:0] wc,
    output logic [WORD-1:0] la,
    output logic [WORD-1:0] lb,
    output logic [WORD-1:0] lc,
    input  logic [WORD-1:0] lres,
    output logic [WORD-1:0] wres
);
    int  lew, lmw;
    logic same;

    assign lew  = exp_bits(cfg.lane_fmt);
    assign lmw  = man_bits(cfg.lane_fmt);
    assign same = (cfg.io_fmt == cfg.lane_fmt);

    function automatic logic [WORD-1:0] prep(input logic [WORD-1:0] x, input cfg_t c,
                                             input logic eq, input int ew, input int mw);
        logic [63:0] d;
        if (eq) return unpad(x, c.io_fmt);
        d = (c.io_fmt == FMT_DBL) ? x : widen_fp(unpad(x, FMT_SGL), 8, 23);
        return narrow_fp(d, ew, mw);
    endfunction

    always_comb begin
        logic [63:0] d;
        la = prep(wa, cfg, same, lew, lmw);
        lb = prep(wb, cfg, same, lew, lmw);
        lc = prep(wc, cfg, same, lew, lmw);
        d  = widen_fp(unpad(lres, cfg.lane_fmt), lew, lmw);
        if (same)                        wres = pad(lres, cfg.io_fmt);
        else if (cfg.io_fmt == FMT_DBL)  wres = d;
        else                             wres = pad(narrow_fp(d, 8, 23), FMT_SGL);
    end
endmodule

// File: rtl/vpd_ctrl.sv
module vpd_ctrl
    import vpd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  cfg_t                       cfg_in,
    input  logic [1:0]                 op_in,
    input  logic [LANES-1:0][WORD-1:0] a_in,
    input  logic [LANES-1:0][WORD-1:0] b_in,
    input  logic [LANES-1:0][WORD-1:0] c_in,
    output cfg_t                       cfg_q,
    output logic [1:0]                 op_q,
    output logic [LANES-1:0][WORD-1:0] a_q,
    output logic [LANES-1:0][WORD-1:0] b_q,
    output logic [LANES-1:0][WORD-1:0] c_q,
    output logic [LANES-1:0]           pend,
    input  logic [LANES-1:0]           ack,
    input  logic [LANES-1:0][WORD-1:0] res_w,
    output logic [LANES-1:0][WORD-1:0] out_q,
    output logic                       done,
    output logic                       err
);
    logic                       busy;
    logic [LANES-1:0]           pend_n;
    logic [LANES-1:0][WORD-1:0] hold, hold_n;

    always_comb begin
        pend_n = pend & ~ack;
        hold_n = hold;
        for (int i = 0; i < LANES; i++)
            if (pend[i] && ack[i]) hold_n[i] = res_w[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pend  <= '0;
            hold  <= '0;
            out_q <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
            cfg_q <= '{ok: 1'b0, count: '0, io_fmt: FMT_NONE, lane_fmt: FMT_NONE};
            op_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (!busy) begin
                if (start) begin
                    if (cfg_in.ok) begin
                        cfg_q <= cfg_in;
                        op_q  <= op_in;
                        a_q   <= a_in;
                        b_q   <= b_in;
                        c_q   <= c_in;
                        pend  <= lane_mask(cfg_in.count);
                        busy  <= 1'b1;
                    end else begin
                        err <= 1'b1;
                    end
                end
            end else begin
                pend <= pend_n;
                hold <= hold_n;
                if (pend_n == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    for (int i = 0; i < LANES; i++)
                        out_q[i] <= (i < int'(cfg_q.count)) ? hold_n[i] : '0;
                end
            end
        end
    end
endmodule

// File: rtl/vp_lane_dispatch.sv
module vp_lane_dispatch
    import vpd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [1:0]                 mode,
    input  logic [1:0]                 prec,
    input  logic [1:0]                 opcode,
    input  logic [LANES-1:0][WORD-1:0] op_a,
    input  logic [LANES-1:0][WORD-1:0] op_b,
    input  logic [LANES-1:0][WORD-1:0] op_c,
    output logic [LANES-1:0][WORD-1:0] result,
    output logic                       done,
    output logic                       err,
    output logic [LANES-1:0]           lane_req,
    output logic [1:0]                 lane_fmt,
    output logic [1:0]                 lane_op,
    output logic [LANES-1:0][WORD-1:0] lane_a,
    output logic [LANES-1:0][WORD-1:0] lane_b,
    output logic [LANES-1:0][WORD-1:0] lane_c,
    input  logic [LANES-1:0]           lane_ack,
    input  logic [LANES-1:0][WORD-1:0] lane_res
);
    cfg_t                       cfg_d, cfg_q;
    logic [LANES-1:0][WORD-1:0] a_q, b_q, c_q, res_w;

    vpd_decode dec_i (.mode(mode), .prec(prec), .cfg(cfg_d));

    vpd_ctrl ctrl_i (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_d), .op_in(opcode),
        .a_in(op_a), .b_in(op_b), .c_in(op_c),
        .cfg_q(cfg_q), .op_q(lane_op), .a_q(a_q), .b_q(b_q), .c_q(c_q),
        .pend(lane_req), .ack(lane_ack), .res_w(res_w),
        .out_q(result), .done(done), .err(err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vpd_lane_fmt fmt_i (
            .cfg(cfg_q), .wa(a_q[g]), .wb(b_q[g]), .wc(c_q[g]),
            .la(lane_a[g]), .lb(lane_b[g]), .lc(lane_c[g]),
            .lres(lane_res[g]), .wres(res_w[g])
        );
    end

    assign lane_fmt = cfg_q.lane_fmt;
endmodule

// File: rtl/vpd_checker.sv
module vpd_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       done,
    input logic       err,
    input logic [3:0] lane_req,
    input logic [3:0] lane_ack,
    input logic [1:0] lane_fmt,
    input logic [1:0] lane_op
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> (lane_req == 4'd0));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst) err |-> (!done && lane_req == 4'd0));

    // R1
    dbl_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_req != 4'd0 && lane_fmt == 2'b11) |-> (lane_req[3:1] == 3'd0));

    // R11
    op_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_req != 4'd0) |=> (lane_req == 4'd0 || $stable(lane_op)));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && lane_req != 4'd0) |=> ($stable(lane_fmt) && !err));

    for (genvar i = 0; i < 4; i++) begin : g_hold
        // R9
        req_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (lane_req[i] && !lane_ack[i]) |=> lane_req[i]);
    end
endmodule

bind vp_lane_dispatch vpd_checker chk_i (
    .clk(clk), .rst(rst), .start(start), .done(done), .err(err),
    .lane_req(lane_req), .lane_ack(lane_ack), .lane_fmt(lane_fmt), .lane_op(lane_op)
);

// File: tb/vp_lane_dispatch_tb_top.sv
`timescale 1ns/1ps
module vp_lane_dispatch_tb_top;

    typedef logic [3:0][63:0] quad_t;
    typedef struct { logic e; quad_t o; string tag; } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] mode = 2'b00, prec = 2'b00, opcode = 2'b00;
    quad_t      oa = '0, ob = '0, oc = '0;
    quad_t      result, lane_a, lane_b, lane_c;
    quad_t      lane_res = '0;
    logic [3:0] lane_ack = '0;
    logic [3:0] lane_req;
    logic [1:0] lane_fmt, lane_op;
    logic       done, err;

    int   checks = 0, errors = 0, cyc = 0, lat = 1;
    int   cnt [4] = '{0, 0, 0, 0};
    logic [1:0] exp_fmt = 2'b00, exp_op = 2'b00;
    logic done_prev = 1'b0;
    exp_t sb [$];

    always #5 clk = ~clk;

    vp_lane_dispatch dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .prec(prec), .opcode(opcode),
        .op_a(oa), .op_b(ob), .op_c(oc), .result(result), .done(done), .err(err),
        .lane_req(lane_req), .lane_fmt(lane_fmt), .lane_op(lane_op),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c),
        .lane_ack(lane_ack), .lane_res(lane_res)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // lane model: answers a^b^c after a per-lane delay
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            lane_ack[i] <= 1'b0;
            if (lane_req[i] && !lane_ack[i]) begin
                if (cnt[i] >= lat + i) begin
                    lane_ack[i] <= 1'b1;
                    lane_res[i] <= lane_a[i] ^ lane_b[i] ^ lane_c[i];
                    cnt[i] <= 0;
                    chk(lane_fmt == exp_fmt, "R1-fmt lane format", {62'd0, lane_fmt}, {62'd0, exp_fmt});
                    chk(lane_op == exp_op, "R11 lane opcode", {62'd0, lane_op}, {62'd0, exp_op});
                end else begin
                    cnt[i] <= cnt[i] + 1;
                end
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t it;
        cyc++;
        if (!rst) begin
            if (done) chk(!done_prev, "R9 done single pulse", 64'(done_prev), 64'd0);
            done_prev <= done;
            if (done || err) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected completion", {62'd0, done, err}, 64'd0);
                end else begin
                    it = sb.pop_front();
                    chk(err == it.e, {it.tag, " err flag"}, 64'(err), 64'(it.e));
                    chk(done == !it.e, {it.tag, " done flag"}, 64'(done), 64'(!it.e));
                    for (int i = 0; i < 4; i++)
                        chk(result[i] == it.o[i], $sformatf("%s out%0d", it.tag, i), result[i], it.o[i]);
                end
            end
        end
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push(input logic e, input quad_t o, input string tag);
        exp_t it;
        it.e = e; it.o = o; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic issue(input logic [1:0] m, input logic [1:0] p, input logic [1:0] o,
                         input quad_t a, input quad_t b, input quad_t c, input logic [1:0] f);
        mode = m; prec = p; opcode = o; oa = a; ob = b; oc = c;
        exp_fmt = f; exp_op = o;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [1:0] m, input logic [1:0] p, input logic [1:0] o,
                       input quad_t a, input quad_t b, input quad_t c,
                       input logic [1:0] f, input logic e, input quad_t expo, input string tag);
        push(e, expo, tag);
        @(negedge clk);
        issue(m, p, o, a, b, c, f);
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    localparam logic [63:0] D_ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_70K   = 64'h40F1_1700_0000_0000;
    localparam logic [63:0] D_INF   = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] D_TINY  = 64'h3E70_0000_0000_0000; // 2^-24
    localparam logic [63:0] D_M2    = 64'hC000_0000_0000_0000;
    localparam logic [63:0] S1      = 64'hFFFF_FFFF_0000_0000;
    localparam logic [63:0] H1      = 64'hFFFF_FFFF_FFFF_0000;

    initial begin
        quad_t last;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(result == '0, "R8 reset outputs", result[0], 64'd0);
        chk(!done && !err && lane_req == 4'd0, "R9 reset flags", {59'd0, done, err, lane_req}, 64'd0);

        // R1 exact double on lane 0, garbage in other slots must not leak (R8)
        lat = 2;
        run(2'b11, 2'b11, 2'b11,
            '{64'h1, 64'h2, 64'h3, D_ONE}, '{64'h4, 64'h5, 64'h6, 64'h0000_0000_00F0_F0F0},
            '{64'h7, 64'h8, 64'h9, 64'h1}, 2'b11, 1'b0,
            '{64'd0, 64'd0, 64'd0, 64'h3FF0_0000_00F0_F0F1}, "R1 exact double");

        // R2 two approximate double on single lanes: 70000 exact, tie to even
        lat = 1;
        run(2'b10, 2'b11, 2'b10,
            '{64'h5, 64'h5, 64'h3FF0_0000_1000_0000, D_70K}, '0, '0, 2'b10, 1'b0,
            '{64'd0, 64'd0, D_ONE, D_70K}, "R2 approx double via single");

        // R3 four approximate double on half lanes: round-up tie, overflow, subnormal, sign
        run(2'b01, 2'b11, 2'b01,
            '{D_M2, D_TINY, D_70K, 64'h3FF0_0600_0000_0000}, '0, '0, 2'b01, 1'b0,
            '{D_M2, D_TINY, D_INF, 64'h3FF0_0800_0000_0000}, "R3 approx double via half");

        // R4 exact single, padding with ones
        run(2'b10, 2'b10, 2'b00,
            '{64'h0, 64'h0, S1 | 64'hC000_0000, S1 | 64'h3F80_0000},
            '{64'h0, 64'h0, 64'h0, S1 | 64'h1}, '0, 2'b10, 1'b0,
            '{64'd0, 64'd0, S1 | 64'hC000_0000, S1 | 64'h3F80_0001}, "R4 exact single");

        // R5 approximate single on half lanes
        run(2'b01, 2'b10, 2'b11,
            '{S1 | 64'hC000_0000, S1 | 64'h4788_B800, S1 | 64'h3F80_1000, S1 | 64'h3F80_0000},
            '0, '0, 2'b01, 1'b0,
            '{S1 | 64'hC000_0000, S1 | 64'h7F80_0000, S1 | 64'h3F80_0000, S1 | 64'h3F80_0000},
            "R5 approx single via half");

        // R6 exact half, 48 ones of padding
        last = '{H1 | 64'h0001, H1 | 64'h7C00, H1 | 64'hC000, H1 | 64'h3C01};
        run(2'b01, 2'b01, 2'b10,
            '{H1 | 64'h0001, H1 | 64'h7C00, H1 | 64'hC000, H1 | 64'h3C00},
            '{64'h0, 64'h0, 64'h0, 64'h1}, '0, 2'b01, 1'b0, last, "R6 exact half");

        // R7 unsupported pairs: error pulse, outputs retained
        run(2'b00, 2'b11, 2'b11, '0, '0, '0, 2'b01, 1'b1, last, "R7 unsupported 00/11");
        run(2'b11, 2'b10, 2'b11, '0, '0, '0, 2'b01, 1'b1, last, "R7 unsupported 11/10");
        chk(lane_req == 4'd0, "R7 no lane request", {60'd0, lane_req}, 64'd0);

        // R10 start while busy ignored, start on done cycle accepted
        lat = 6;
        push(1'b0, '{64'd0, 64'd0, 64'd0, D_ONE ^ 64'h10}, "R10 first op");
        push(1'b0, '{64'd0, 64'd0, S1 | 64'h3F80_0000, S1 | 64'h4000_0000}, "R10 done-cycle op");
        @(negedge clk);
        issue(2'b11, 2'b11, 2'b01, '{64'h0, 64'h0, 64'h0, D_ONE},
              '{64'h0, 64'h0, 64'h0, 64'h10}, '0, 2'b11);
        @(negedge clk);
        // unsupported pair while busy: would pulse err if taken
        mode = 2'b00; prec = 2'b00; opcode = 2'b10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        lat = 1;
        issue(2'b10, 2'b10, 2'b10, '{64'h0, 64'h0, S1 | 64'h3F80_0000, S1 | 64'h4000_0000},
              '0, '0, 2'b10);
        wait (sb.size() == 0);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule